// File: doc/BRIEF.md
# Per-Port Spanning Tree Forwarding Gate

This block holds a two-bit spanning-tree state for each port of a small switch (three ports by default: the host port plus two network ports). Software running the protocol state machine writes a port's state through a simple write strobe. For every frame event the switch engine presents a port number, an event kind and the override flag of the matched address-table entry. One cycle later the block answers with exactly one of two outputs: permit or drop.

Receive, transmit and source-address learning are gated separately. The blocking state is also used for a disabled port, and the hardware treats the two the same way. The override flag lets protocol frames that are addressed to the host be received on a port that is not forwarding. The flag has no effect on transmit or on learning. After reset every port is forwarding. The host port is normally left in that state.

Top module: `stp_port_gate`

## Requirements
- R1: After reset, all ports are in the forwarding state and both decision outputs are low.
- R2: State code 2'b00 (forwarding) permits receive, transmit and learn events.
- R3: State code 2'b01 (blocking, also used for disabled) drops transmit and learn events, and drops receive events whose override flag is clear.
- R4: State code 2'b10 (learning) permits learn events, and drops transmit events and receive events whose override flag is clear.
- R5: State code 2'b11 (listening) drops transmit and learn events, and drops receive events whose override flag is clear.
- R6: A receive event with the override flag set is permitted on a valid port, whatever that port's state.
- R7: The override flag never changes the result of a transmit or learn event.
- R8: An event presented in one cycle produces, in the next cycle, a valid strobe together with exactly one of permit or drop. Permit and drop are both low when no decision is valid.
- R9: A state write is applied to events in later cycles. An event in the same cycle as a write to its port still uses the previous state.
- R10: Event kind codes are 2'b00 receive, 2'b01 transmit and 2'b10 learn. The code 2'b11 is reserved and is always dropped.
- R11: An event on a port index at or above the port count is always dropped, even with override. A state write to such an index changes no port.
- R12: Each port's state is independent. A write to one port does not change the decisions for another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | State write strobe |
| cfg_port | input | PW (2) | Port index that the write targets |
| cfg_state | input | 2 | New state code |
| ev_valid | input | 1 | A frame event is presented this cycle |
| ev_port | input | PW (2) | Port index of the event |
| ev_kind | input | 2 | Event kind: receive, transmit, learn or reserved |
| ev_override | input | 1 | Override flag from the matched address entry |
| dec_valid | output | 1 | Decision valid, one cycle after the event |
| dec_permit | output | 1 | The event is allowed |
| dec_drop | output | 1 | The event is refused |

## Verification
A state write and a frame decision can fall in the same cycle and target the same port. In that case the decision must still use the state in force before the write. The bench provokes this directly by writing blocking to a forwarding port while a transmit event for that port is presented. It expects permit in that decision and drop for an identical event in the following cycle. The random phase also produces many write-and-event collisions. Its reference model computes each expected result from the stored state before applying the write.

// File: rtl/stg_pkg.sv
package stg_pkg;

  typedef enum logic [1:0] {
    ST_FWD = 2'b00,
    ST_BLK = 2'b01,
    ST_LRN = 2'b10,
    ST_LSN = 2'b11
  } stp_state_e;

  typedef enum logic [1:0] {
    EV_RX  = 2'b00,
    EV_TX  = 2'b01,
    EV_LRN = 2'b10,
    EV_RSV = 2'b11
  } ev_kind_e;

  typedef struct packed {
    logic permit;
    logic drop;
  } verdict_t;

endpackage

// File: rtl/stg_rst_sync.sv
module stg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/stg_state_bank.sv
module stg_state_bank #(
  parameter int NUM_PORTS = 3,
  parameter int PW        = 2
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        wr_en,
  input  logic [PW-1:0]               wr_port,
  input  logic [1:0]                  wr_state,
  output logic [NUM_PORTS-1:0][1:0]   state_q
);
  import stg_pkg::*;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic       hit;
    logic [1:0] st_d;

    always_comb begin
      hit  = wr_en && (int'(wr_port) == p);
      st_d = hit ? wr_state : state_q[p];
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[p] <= ST_FWD;
      end else if (hit) begin
        state_q[p] <= st_d;
      end
    end
  end

endmodule

// File: rtl/stg_rule.sv
module stg_rule (
  input  logic                 port_ok,
  input  logic [1:0]           state,
  input  logic [1:0]           kind,
  input  logic                 override,
  output stg_pkg::verdict_t    verdict
);
  import stg_pkg::*;

  logic allow;

  always_comb begin
    allow = 1'b0;
    unique case (ev_kind_e'(kind))
      EV_RX:   allow = (state == ST_FWD) || override;
      EV_TX:   allow = (state == ST_FWD);
      EV_LRN:  allow = (state == ST_FWD) || (state == ST_LRN);
      default: allow = 1'b0;
    endcase
    verdict.permit = port_ok && allow;
    verdict.drop   = !(port_ok && allow);
  end

endmodule

// File: rtl/stp_port_gate.sv
module stp_port_gate #(
  parameter int NUM_PORTS = 3,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_port,
  input  logic [1:0]    cfg_state,
  input  logic          ev_valid,
  input  logic [PW-1:0] ev_port,
  input  logic [1:0]    ev_kind,
  input  logic          ev_override,
  output logic          dec_valid,
  output logic          dec_permit,
  output logic          dec_drop
);
  import stg_pkg::*;

  logic                      rst_int_n;
  logic [NUM_PORTS-1:0][1:0] state_q;
  logic [1:0]                sel_state;
  logic                      port_ok;
  verdict_t                  rule_v;
  verdict_t                  verdict_d;
  verdict_t                  verdict_q;
  logic                      valid_d;
  logic                      valid_q;

  stg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  stg_state_bank #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_bank (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .wr_en    (cfg_we),
    .wr_port  (cfg_port),
    .wr_state (cfg_state),
    .state_q  (state_q)
  );

  always_comb begin
    port_ok   = (int'(ev_port) < NUM_PORTS);
    sel_state = ST_FWD;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(ev_port) == p) begin
        sel_state = state_q[p];
      end
    end
  end

  stg_rule u_rule (
    .port_ok  (port_ok),
    .state    (sel_state),
    .kind     (ev_kind),
    .override (ev_override),
    .verdict  (rule_v)
  );

  always_comb begin
    valid_d   = ev_valid;
    verdict_d = ev_valid ? rule_v : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      valid_q   <= valid_d;
      verdict_q <= verdict_d;
    end
  end

  assign dec_valid  = valid_q;
  assign dec_permit = verdict_q.permit;
  assign dec_drop   = verdict_q.drop;

endmodule

// File: rtl/stp_port_gate_chk.sv
module stp_port_gate_chk #(
  parameter int NUM_PORTS = 3,
  parameter int PW        = 2
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          ev_valid,
  input logic [PW-1:0] ev_port,
  input logic [1:0]    ev_kind,
  input logic          ev_override,
  input logic          dec_valid,
  input logic          dec_permit,
  input logic          dec_drop
);

  logic port_ok;
  assign port_ok = (int'(ev_port) < NUM_PORTS);

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    dec_valid |-> (dec_permit ^ dec_drop));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !dec_valid |-> (!dec_permit && !dec_drop));

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_valid |=> dec_valid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !ev_valid |=> !dec_valid);

  assert_rsv_drop_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (ev_valid && ev_kind == 2'b11) |=> dec_drop);

  assert_badport_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (ev_valid && !port_ok) |=> dec_drop);

  assert_ovr_rx_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (ev_valid && port_ok && ev_kind == 2'b00 && ev_override) |=> dec_permit);

endmodule

bind stp_port_gate stp_port_gate_chk #(.NUM_PORTS(NUM_PORTS), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_int_n),
  .ev_valid    (ev_valid),
  .ev_port     (ev_port),
  .ev_kind     (ev_kind),
  .ev_override (ev_override),
  .dec_valid   (dec_valid),
  .dec_permit  (dec_permit),
  .dec_drop    (dec_drop)
);

// File: tb/stp_port_gate_test.sv
module stp_port_gate_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_port;
  logic [1:0] cfg_state;
  logic       ev_valid;
  logic [1:0] ev_port;
  logic [1:0] ev_kind;
  logic       ev_override;
  logic       dec_valid;
  logic       dec_permit;
  logic       dec_drop;

  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  logic [1:0] model [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  stp_port_gate #(.NUM_PORTS(NP)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_port(cfg_port), .cfg_state(cfg_state),
    .ev_valid(ev_valid), .ev_port(ev_port), .ev_kind(ev_kind),
    .ev_override(ev_override),
    .dec_valid(dec_valid), .dec_permit(dec_permit), .dec_drop(dec_drop)
  );

  function automatic logic exp_permit(input logic [1:0] st, input logic [1:0] kind,
                                      input logic ovr, input logic [1:0] port);
    if (int'(port) >= NP) return 1'b0;
    case (kind)
      2'b00:   return (st == 2'b00) || ovr;
      2'b01:   return (st == 2'b00);
      2'b10:   return (st == 2'b00) || (st == 2'b10);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] wp, input logic [1:0] ws,
                      input logic ev, input logic [1:0] ep, input logic [1:0] ek,
                      input logic eo, input string req);
    logic [1:0] st;
    logic       pe;
    cfg_we = we; cfg_port = wp; cfg_state = ws;
    ev_valid = ev; ev_port = ep; ev_kind = ek; ev_override = eo;
    st = (int'(ep) < NP) ? model[ep] : 2'b00;
    pe = exp_permit(st, ek, eo, ep);
    if (we && int'(wp) < NP) model[wp] = ws;
    @(negedge clk);
    chk({req, " valid"}, dec_valid, ev);
    if (ev) begin
      chk({req, " permit"}, dec_permit, pe);
      chk({req, " drop"}, dec_drop, !pe);
    end else begin
      chk({req, " idle"}, dec_permit | dec_drop, 1'b0);
    end
    cfg_we = 1'b0; ev_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] p, input logic [1:0] s, input string req);
    step(1'b1, p, s, 1'b0, 2'd0, 2'd0, 1'b0, req);
  endtask

  task automatic ev(input logic [1:0] p, input logic [1:0] k, input logic o, input string req);
    step(1'b0, 2'd0, 2'd0, 1'b1, p, k, o, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NP; i++) model[i] = 2'b00;
    rst_n = 1'b0; cfg_we = 0; cfg_port = 0; cfg_state = 0;
    ev_valid = 0; ev_port = 0; ev_kind = 0; ev_override = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset outputs low, every port forwarding
    chk("R1 dec_valid", dec_valid, 1'b0);
    chk("R1 permit|drop", dec_permit | dec_drop, 1'b0);
    for (int p = 0; p < NP; p++) begin
      ev(2'(p), 2'b01, 1'b0, "R1 tx after reset");
      ev(2'(p), 2'b00, 1'b0, "R2 rx forwarding");
      ev(2'(p), 2'b10, 1'b0, "R2 learn forwarding");
    end

    // R3 blocking on port 1, R12 port 0 untouched
    wr(2'd1, 2'b01, "R3 write");
    ev(2'd1, 2'b00, 1'b0, "R3 rx blocked");
    ev(2'd1, 2'b01, 1'b0, "R3 tx blocked");
    ev(2'd1, 2'b10, 1'b0, "R3 learn blocked");
    ev(2'd1, 2'b00, 1'b1, "R6 rx override blocked");
    ev(2'd1, 2'b01, 1'b1, "R7 tx override blocked");
    ev(2'd1, 2'b10, 1'b1, "R7 learn override blocked");
    ev(2'd0, 2'b01, 1'b0, "R12 port0 still forwarding");
    ev(2'd2, 2'b00, 1'b0, "R12 port2 still forwarding");

    // R4 learning on port 2
    wr(2'd2, 2'b10, "R4 write");
    ev(2'd2, 2'b10, 1'b0, "R4 learn allowed");
    ev(2'd2, 2'b00, 1'b0, "R4 rx dropped");
    ev(2'd2, 2'b01, 1'b0, "R4 tx dropped");
    ev(2'd2, 2'b00, 1'b1, "R6 rx override learning");
    ev(2'd2, 2'b01, 1'b1, "R7 tx override learning");

    // R5 listening on port 2
    wr(2'd2, 2'b11, "R5 write");
    ev(2'd2, 2'b00, 1'b0, "R5 rx dropped");
    ev(2'd2, 2'b01, 1'b0, "R5 tx dropped");
    ev(2'd2, 2'b10, 1'b0, "R5 learn dropped");
    ev(2'd2, 2'b00, 1'b1, "R6 rx override listening");
    ev(2'd2, 2'b10, 1'b1, "R7 learn override listening");

    // R9 write and event collide on port 0
    step(1'b1, 2'd0, 2'b01, 1'b1, 2'd0, 2'b01, 1'b0, "R9 same-cycle uses old state");
    ev(2'd0, 2'b01, 1'b0, "R9 next cycle uses new state");
    wr(2'd0, 2'b00, "R9 restore");

    // R10 reserved kind
    ev(2'd0, 2'b11, 1'b1, "R10 reserved dropped");

    // R11 out-of-range port
    ev(2'd3, 2'b00, 1'b1, "R11 bad port rx override");
    ev(2'd3, 2'b01, 1'b0, "R11 bad port tx");
    wr(2'd3, 2'b01, "R11 write bad port");
    ev(2'd0, 2'b01, 1'b0, "R11 port0 unchanged");
    ev(2'd1, 2'b00, 1'b1, "R11 port1 unchanged");
    ev(2'd2, 2'b10, 1'b0, "R11 port2 unchanged");

    // random phase, R8 plus collisions
    for (int n = 0; n < 600; n++) begin
      step(($urandom % 3) == 0, 2'($urandom), 2'($urandom),
           ($urandom % 4) != 0, 2'($urandom), 2'($urandom), 1'($urandom),
           "R8 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule